// File: doc/BRIEF.md
# Retriggerable Hardware Strobe Counter

A single down-counter channel of an interval timer, hard-wired for the hardware-triggered strobe behaviour. Software first writes a configuration byte and then an initial count N, one or two bytes wide. The channel stays idle until a rising edge appears on `gate_i`. The clock edge after that trigger loads N without decrementing. The count then runs down, and `out_o` goes low for exactly one clock, N+1 clocks after the trigger.

Every further rising edge on `gate_i` reloads the count that is currently programmed, which restarts the delay. A count written while the channel is counting waits for the next trigger. Rising edges on `gate_i` are caught by a capture stage that does not depend on the clock. A pulse that comes and goes between two clock edges is therefore still seen.

Top module: `retrig_strobe_timer`

## Requirements
- R1: A configuration write (`ctrl_we_i`=1) forces `out_o` high in the same cycle, without waiting for a clock edge. It cancels any sequence in progress, discards a pending trigger and marks the stored count invalid, so `out_o` stays high until a new count and a new trigger arrive.
- R2: Configuration byte fields:
  - Bits [3:1] hold the mode. Only 3'b101 enables the channel; with any other value, triggers are ignored and `out_o` stays high.
  - Bit 5 selects the count format. With bit 5 = 0, each count write loads the low byte and zeroes the high byte (0x1A). With bit 5 = 1, the low byte is written first and the high byte second, and the count takes effect on the second write (0x3A).
- R3: Until a complete count has been written after the configuration, triggers are ignored. Without a trigger, nothing happens and `out_o` stays high.
- R4: A trigger is sampled at clock edge k. That edge loads N and does not decrement it. `out_o` is low from edge k+N to edge k+N+1, so the low cycle is the (N+1)-th clock counting the load edge.
- R5: `out_o` is low for exactly one clock per expiry.
- R6: A programmed count of 0 acts as 65536.
- R7: A trigger while counting reloads the count. The strobe then comes N+1 clocks after the latest trigger, and none comes for the earlier one.
- R8: A count written during counting does not change the sequence in progress. The next trigger loads the new value.
- R9: A `gate_i` pulse that rises and falls between two clock edges is still a trigger. Several rising edges between the same two clock edges count as one trigger.
- R10: The level of `gate_i` has no effect. Holding `gate_i` high after a rising edge does not retrigger.
- R11: After the strobe the counter keeps counting down and wraps, but produces no further strobe until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | Trigger input; rising edges start or restart counting |
| ctrl_we_i | input | 1 | Configuration write strobe; `data_i` holds the configuration byte |
| cnt_we_i | input | 1 | Count write strobe; `data_i` holds one count byte |
| data_i | input | BYTE_W | Shared write data |
| out_o | output | 1 | Strobe output, idle high, low for one clock on expiry |

## Verification
The bench builds the block with its defaults: a 16-bit counter written through an 8-bit data bus. Two-byte loading and the 65536-clock zero count are therefore exercised directly, and the count wraps from zero after a strobe. Gate pulses are driven between clock edges and are only half a nanosecond wide, so every trigger depends on the edge capture stage rather than on level sampling.

// File: rtl/strobe_timer_pkg.sv
`timescale 1ns/1ps
package strobe_timer_pkg;
  localparam logic [2:0] MODE_HW_STROBE = 3'b101;

  typedef struct packed {
    logic [2:0] mode;
    logic       two_byte;
  } cfg_t;
endpackage

// File: rtl/stt_gate_capture.sv
`timescale 1ns/1ps
// Req/ack edge capture: req flips on a gate rise only when nothing is pending,
// the clock domain acknowledges on every edge.
module stt_gate_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic trig_o
);
  logic req_q;
  logic ack_q;

  always_ff @(posedge gate_i or negedge rst_ni) begin
    if (!rst_ni)             req_q <= 1'b0;
    else if (req_q == ack_q) req_q <= ~req_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req_q;
  end

  assign trig_o = req_q ^ ack_q;
endmodule

// File: rtl/stt_count_prog.sv
`timescale 1ns/1ps
module stt_count_prog
  import strobe_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              cnt_we_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CNT_W-1:0]  init_o,
  output logic              valid_o,
  output logic              cfg_ok_o
);
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBYTES - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

  cfg_t             cfg_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] stage_q;
  logic [CNT_W-1:0] init_q;
  logic             valid_q;
  logic [CNT_W-1:0] stage_nxt;

  always_comb begin
    stage_nxt = stage_q;
    stage_nxt[int'(ptr_q)*BYTE_W +: BYTE_W] = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      ptr_q   <= '0;
      stage_q <= '0;
      init_q  <= '0;
      valid_q <= 1'b0;
    end else if (ctrl_we_i) begin
      cfg_q.mode     <= data_i[3:1];
      cfg_q.two_byte <= data_i[5];
      ptr_q          <= '0;
      stage_q        <= '0;
      valid_q        <= 1'b0;
    end else if (cnt_we_i) begin
      if (!cfg_q.two_byte) begin
        init_q  <= CNT_W'(data_i);
        valid_q <= 1'b1;
      end else if (ptr_q == PTR_LAST) begin
        init_q  <= stage_nxt;
        valid_q <= 1'b1;
        ptr_q   <= '0;
      end else begin
        stage_q <= stage_nxt;
        ptr_q   <= ptr_q + PTR_ONE;
      end
    end
  end

  assign init_o   = init_q;
  assign valid_o  = valid_q;
  assign cfg_ok_o = (cfg_q.mode == MODE_HW_STROBE);
endmodule

// File: rtl/stt_down_counter.sv
`timescale 1ns/1ps
module stt_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             low_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             running_q;
  logic             armed_q;
  logic             low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
      armed_q   <= 1'b0;
      low_q     <= 1'b0;
    end else if (clr_i) begin
      running_q <= 1'b0;
      armed_q   <= 1'b0;
      low_q     <= 1'b0;
    end else if (load_i) begin
      // load edge does not decrement; 0 loads as full range
      cnt_q     <= init_i;
      running_q <= 1'b1;
      armed_q   <= 1'b1;
      low_q     <= 1'b0;
    end else if (running_q) begin
      cnt_q <= cnt_q - ONE;
      if (armed_q && cnt_q == ONE) begin
        low_q   <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        low_q <= 1'b0;
      end
    end else begin
      low_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = running_q;
  assign low_o     = low_q;
endmodule

// File: rtl/retrig_strobe_timer.sv
`timescale 1ns/1ps
module retrig_strobe_timer #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic              ctrl_we_i,
  input  logic              cnt_we_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              out_o
);
  logic             trig_s;
  logic             valid_s;
  logic             cfg_ok_s;
  logic [CNT_W-1:0] init_s;
  logic             load_s;
  logic [CNT_W-1:0] cnt_s;
  logic             running_s;
  logic             low_s;

  stt_gate_capture u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .trig_o (trig_s)
  );

  stt_count_prog #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we_i),
    .cnt_we_i  (cnt_we_i),
    .data_i    (data_i),
    .init_o    (init_s),
    .valid_o   (valid_s),
    .cfg_ok_o  (cfg_ok_s)
  );

  assign load_s = trig_s & valid_s & cfg_ok_s & ~ctrl_we_i;

  stt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ctrl_we_i),
    .load_i    (load_s),
    .init_i    (init_s),
    .cnt_o     (cnt_s),
    .running_o (running_s),
    .low_o     (low_s)
  );

  // configuration write drives the output high without a clock edge
  assign out_o = ~low_s | ctrl_we_i;
endmodule

// File: rtl/stt_checker.sv
`timescale 1ns/1ps
module stt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic             out_o,
  input logic             load_i,
  input logic             running_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_CTRL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> out_o); // R1
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |-> out_o); // R3
  AST_LOAD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> out_o); // R4
  AST_STROBE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_o |-> (cnt_i == '0)); // R4
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_o |=> out_o); // R5
  AST_WRAP_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && !load_i && !ctrl_we_i) |=> (cnt_i == $past(cnt_i) - ONE)); // R11
endmodule

bind retrig_strobe_timer stt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_we_i (ctrl_we_i),
  .out_o     (out_o),
  .load_i    (load_s),
  .running_i (running_s),
  .cnt_i     (cnt_s)
);

// File: tb/retrig_strobe_timer_tb.sv
`timescale 1ns/1ps
module retrig_strobe_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate = 1'b0;
  logic       ctrl_we = 1'b0;
  logic       cnt_we = 1'b0;
  logic [7:0] data = 8'h00;
  logic       out_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference state derived from the requirements
  bit          m_active, m_low, m_valid, m_two, m_trig;
  int          m_rem, m_ptr;
  logic [2:0]  m_mode;
  logic [15:0] m_init;
  logic [7:0]  m_lo;
  bit          w_ctrl, w_cnt;
  logic [7:0]  w_data;

  always #2.5 clk = ~clk;

  retrig_strobe_timer u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .gate_i    (gate),
    .ctrl_we_i (ctrl_we),
    .cnt_we_i  (cnt_we),
    .data_i    (data),
    .out_o     (out_o)
  );

  function automatic int eff_count(logic [15:0] v);
    return (v == 16'd0) ? 65536 : int'(v);
  endfunction

  function automatic void model_edge();
    if (w_ctrl) begin
      m_active = 0; m_low = 0; m_valid = 0; m_ptr = 0; m_trig = 0;
      m_mode = w_data[3:1]; m_two = w_data[5];
    end else begin
      m_low = 0;
      if (m_trig && m_valid && m_mode == 3'b101) begin
        m_rem = eff_count(m_init); m_active = 1;
      end else if (m_active) begin
        m_rem--;
        if (m_rem == 0) begin m_low = 1; m_active = 0; end
      end
      m_trig = 0;
      if (w_cnt) begin
        if (!m_two) begin
          m_init = {8'h00, w_data}; m_valid = 1;
        end else if (m_ptr == 0) begin
          m_lo = w_data; m_ptr = 1;
        end else begin
          m_init = {w_data, m_lo}; m_valid = 1; m_ptr = 0;
        end
      end
    end
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk); #1;
    model_edge();
    ctrl_we = 1'b0; cnt_we = 1'b0; w_ctrl = 0; w_cnt = 0;
    #1;
    check(tag, out_o, !m_low);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; data = v; w_ctrl = 1; w_data = v;
    #0.5;
    check("R1 immediate high", out_o, 1'b1);
    tick("R1");
  endtask

  task automatic wr_cnt(input logic [7:0] v, input string tag);
    cnt_we = 1'b1; data = v; w_cnt = 1; w_data = v;
    tick(tag);
  endtask

  task automatic pulse();
    gate = 1'b1; m_trig = 1;
    #0.5;
    gate = 1'b0;
  endtask

  initial begin
    #990000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_active = 0; m_low = 0; m_valid = 0; m_two = 0; m_trig = 0;
    m_rem = 0; m_ptr = 0; m_mode = 3'b000; m_init = 16'h0; m_lo = 8'h0;
    w_ctrl = 0; w_cnt = 0; w_data = 8'h0;

    repeat (3) @(posedge clk);
    #1 check("reset R5", out_o, 1'b1);
    #1 rst_n = 1'b1;
    ticks(2, "reset");

    // R3: configured, no count yet: triggers ignored
    wr_ctrl(8'h1A);
    pulse(); ticks(8, "R3 no count");
    // R3: count written, no trigger: idle
    wr_cnt(8'd3, "R3");
    ticks(10, "R3 idle");
    // R4/R5: N=3 strobe at k+3, one cycle
    pulse(); ticks(8, "R4 N=3");
    // R4: N=1
    wr_cnt(8'd1, "R4");
    pulse(); ticks(5, "R4 N=1");

    // R9: double short pulse between edges counts once
    wr_cnt(8'd4, "R9");
    pulse(); #0.5; pulse();
    ticks(9, "R9 double pulse");

    // R10: gate held high, single strobe
    gate = 1'b1; m_trig = 1;
    ticks(20, "R10 level");
    gate = 1'b0;
    ticks(3, "R10");

    // R7: retrigger mid-count
    wr_cnt(8'd6, "R7");
    pulse(); ticks(3, "R7");
    pulse(); ticks(4, "R7");
    pulse(); ticks(10, "R7 retrigger");

    // R8: new count while counting
    wr_cnt(8'd8, "R8");
    pulse(); ticks(2, "R8");
    wr_cnt(8'd2, "R8 write during count");
    ticks(10, "R8 old count kept");
    pulse(); ticks(5, "R8 new count");

    // R1: configuration write aborts a running sequence
    wr_cnt(8'd5, "R1");
    pulse(); ticks(2, "R1");
    pulse();
    wr_ctrl(8'h1A);
    ticks(10, "R1 aborted");
    pulse(); ticks(4, "R1 count invalid");

    // R2: two-byte load 0x0102 = 258
    wr_ctrl(8'h3A);
    wr_cnt(8'h02, "R2 low byte");
    pulse(); ticks(4, "R2 half written");
    wr_cnt(8'h01, "R2 high byte");
    pulse(); ticks(262, "R2 two-byte");
    // R2: back to low-only, high byte forced to zero
    wr_ctrl(8'h1A);
    wr_cnt(8'h04, "R2 low only");
    pulse(); ticks(8, "R2 high zero");
    // R2: other mode ignores triggers
    wr_ctrl(8'h14);
    wr_cnt(8'h02, "R2 other mode");
    pulse(); ticks(8, "R2 other mode");

    // R6/R11: zero count is 65536, then wrap with no second strobe
    wr_ctrl(8'h1A);
    wr_cnt(8'h00, "R6");
    pulse(); ticks(65540, "R6 zero count");
    ticks(300, "R11 wrap");

    // random mix of writes and triggers
    wr_cnt(8'd3, "R7");
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 39);
      if (r == 0) wr_ctrl(8'h1A);
      else if (r < 6) wr_cnt(8'($urandom_range(1, 7)), "R8 random");
      else if (r < 14) begin pulse(); tick("R7 random"); end
      else tick("R7 random");
    end
    ticks(10, "R5 tail");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule